// File: doc/BRIEF.md
# I2C Register-Write Target

This block is an I2C target that accepts write transactions into a bank of 22 byte-wide control registers. SCL and SDA are sampled with a fast system clock. Each line passes through a two-flop synchronizer and a glitch filter. START, STOP and SCL edges are then found from the filtered lines. A transaction carries a 7-bit device address and an R/W bit. Then comes one register sub-address byte, then any number of data bytes. Each data byte is stored at the current pointer, and the pointer then moves on to the next register. The whole bank is presented as one flat parallel output, so the surrounding logic reads its settings directly.

The device address has a fixed five-bit prefix `00100`, followed by two low bits taken from the `addr_pins` input. The target pulls SDA low to acknowledge. It does this through the `sda_oe` output, which the pad turns into an open-drain low. The system clock must run at least 8 times faster than SCL. This supports fast-mode SCL rates up to 400 kHz.

The control state machine has these states:
- ST_IDLE: the bus is free.
- ST_ADDR: the address byte is being shifted in.
- ST_ADDR_ACK: the address acknowledge is being driven.
- ST_SUB: the sub-address byte is being shifted in.
- ST_SUB_ACK: the sub-address acknowledge is being driven.
- ST_DATA: a data byte is being shifted in.
- ST_DATA_ACK: the data acknowledge is being driven.
- ST_IGNORE: the target is deselected and waits for the bus.

It has these transitions:
- Any state goes to ST_ADDR on a START, and to ST_IDLE on a STOP.
- ST_ADDR goes to ST_ADDR_ACK on a matching address, or to ST_IGNORE otherwise. This is decided on the SCL fall after the eighth bit.
- ST_ADDR_ACK goes to ST_SUB for a write, or to ST_IGNORE for a read. This happens on the SCL fall that ends the ninth clock.
- ST_SUB goes to ST_SUB_ACK, and ST_SUB_ACK goes to ST_DATA.
- ST_DATA goes to ST_DATA_ACK, which commits the byte, and ST_DATA_ACK goes back to ST_DATA.

Top module: `i2c_regwr_target`

## Requirements
- R1: A START is recognised only when SDA falls while SCL is high, and a STOP only when SDA rises while SCL is high. An address byte clocked without a preceding START gets no acknowledge.
- R2: The target acknowledges the address byte only when its upper seven bits equal `00100` followed by `addr_pins[1:0]`, where bit 1 is the more significant. The eighth bit is R/W, with 0 meaning write.
- R3: After an address that does not match, no acknowledge is given and no register changes until the next START.
- R4: The low five bits of the sub-address byte load the register pointer. The upper three bits are ignored.
- R5: Each data byte, received MSB first, is acknowledged and written to the register at the pointer. Register n appears on `regs_o[8n+7:8n]`.
- R6: After each data byte the pointer advances by one, so a burst fills consecutive registers.
- R7: The pointer goes from 0x15 to 0x00, so a long burst overwrites the lowest registers.
- R8: A data byte whose pointer lies in 0x16..0x1F is acknowledged but discarded, and the pointer then goes to 0x00.
- R9: For an address with R/W = 1, the address is acknowledged but SDA is released afterwards. Later bytes are neither acknowledged nor written.
- R10: A repeated START in the middle of a byte discards the partial byte and restarts address decoding.
- R11: A STOP in the middle of a data byte returns the target to idle without writing the partial byte.
- R12: The acknowledge (`sda_oe` high) changes only while the filtered SCL is low. It is released on the SCL fall that ends the ninth clock.
- R13: After reset all registers read 0x00 and `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL level seen at the pad |
| sda_i | input | 1 | SDA level seen at the pad (wired bus value) |
| addr_pins | input | 2 | Hard-wired low two bits of the device address |
| sda_oe | output | 1 | 1 = pull SDA low (open-drain acknowledge) |
| regs_o | output | 176 | Register bank, register n in bits [8n+7:8n] |

## Verification
The assertions assume a well-formed bus. SDA moves only while SCL is low, except for START and STOP. Every level is held for longer than the synchronizer plus filter latency. The master never raises SDA while the target is pulling it low. The bench builds the SDA bus as the AND of the master's drive and the target's release. It changes SDA a full quarter period after an SCL fall. A quarter period is 8 system clocks, against a filter latency of about 5 clocks, so every START, STOP and data edge is seen cleanly.

// File: rtl/i2c_regwr_pkg.sv
package i2c_regwr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_IGNORE
    } tgt_state_t;

    localparam logic [4:0] DEV_PREFIX = 5'b00100;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            cnt_q  <= '0;
            line_o <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] == line_o) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(FILT_LEN - 1)) begin
                cnt_q  <= '0;
                line_o <= sync_q[1];
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    AST_FILTER_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_o) |-> line_o == $past(sync_q[1])); // R1
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_o,
    output logic stop_o,
    output logic scl_rise_o,
    output logic scl_fall_o
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    always_comb begin
        start_o    = scl_f & scl_p & sda_p & ~sda_f;
        stop_o     = scl_f & scl_p & ~sda_p & sda_f;
        scl_rise_o = scl_f & ~scl_p;
        scl_fall_o = ~scl_f & scl_p;
    end

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_o, stop_o, scl_rise_o, scl_fall_o})); // R1
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
    parameter int NREG  = 22,
    parameter int PTR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [7:0]        wdata,
    output logic [NREG*8-1:0] regs_o
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_o[g*8 +: 8] <= 8'h00;
            end else if (we && waddr == PTR_W'(g)) begin
                regs_o[g*8 +: 8] <= wdata;
            end
        end
    end

    AST_WRITE_ADDR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> waddr < PTR_W'(NREG)); // R8
endmodule

// File: rtl/i2c_regwr_target.sv
module i2c_regwr_target
    import i2c_regwr_pkg::*;
#(
    parameter int NREG     = 22,
    parameter int SUB_W    = 5,
    parameter int FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [1:0]        addr_pins,
    output logic              sda_oe,
    output logic [NREG*8-1:0] regs_o
);
    localparam logic [SUB_W-1:0] LAST_REG = SUB_W'(NREG - 1);

    logic scl_f, sda_f;
    logic start_ev, stop_ev, scl_rise, scl_fall;

    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .line_o(scl_f));
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .line_o(sda_f));

    i2c_cond_detect u_cond (
        .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
        .start_o(start_ev), .stop_o(stop_ev),
        .scl_rise_o(scl_rise), .scl_fall_o(scl_fall));

    tgt_state_t       state_q, state_d;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic             rw_q;
    logic [SUB_W-1:0] ptr_q;
    logic             byte_done;
    logic             addr_match;
    logic             receiving;
    logic             we;

    always_comb begin
        byte_done  = scl_fall && (bit_cnt == 4'd8);
        addr_match = (shreg[7:1] == {DEV_PREFIX, addr_pins});
        receiving  = (state_q == ST_ADDR) || (state_q == ST_SUB) || (state_q == ST_DATA);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_ev) begin
            state_d = ST_IDLE;
        end else if (start_ev) begin
            state_d = ST_ADDR;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_done) state_d = addr_match ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)  state_d = rw_q ? ST_IGNORE : ST_SUB;
                ST_SUB:      if (byte_done) state_d = ST_SUB_ACK;
                ST_SUB_ACK:  if (scl_fall)  state_d = ST_DATA;
                ST_DATA:     if (byte_done) state_d = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall)  state_d = ST_DATA;
                ST_IGNORE:   state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // datapath: bit counter, shifter, direction, pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            rw_q    <= 1'b0;
            ptr_q   <= '0;
        end else if (start_ev || stop_ev) begin
            bit_cnt <= '0;
        end else if (receiving) begin
            if (scl_rise) begin
                shreg   <= {shreg[6:0], sda_f};
                bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_done) begin
                bit_cnt <= '0;
                unique case (state_q)
                    ST_ADDR: rw_q  <= shreg[0];
                    ST_SUB:  ptr_q <= shreg[SUB_W-1:0];
                    ST_DATA: ptr_q <= (ptr_q >= LAST_REG) ? '0 : ptr_q + 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe = (state_q == ST_ADDR_ACK) || (state_q == ST_SUB_ACK) ||
                 (state_q == ST_DATA_ACK);
        we     = (state_q == ST_DATA) && byte_done && !start_ev && !stop_ev &&
                 (ptr_q <= LAST_REG);
    end

    i2c_reg_bank #(.NREG(NREG), .PTR_W(SUB_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(ptr_q), .wdata(shreg),
        .regs_o(regs_o));

    AST_ACK_EDGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f); // R12
    AST_WRITE_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !scl_f && bit_cnt == 4'd8); // R5
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        we && ptr_q == LAST_REG |=> ptr_q == '0); // R7
    AST_START_CLEARS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> bit_cnt == 4'd0 && state_q == ST_ADDR); // R10
endmodule

// File: tb/sim_i2c_regwr_target.sv
`timescale 1ns/1ps
module sim_i2c_regwr_target;
    localparam int NREG = 22;
    localparam int Q    = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [1:0] pins = 2'b10;
    logic sda_oe;
    logic [NREG*8-1:0] regs;
    logic sda_line;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_regwr_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_pins(pins), .sda_oe(sda_oe), .regs_o(regs));

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_regs [NREG];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b0; wq(1);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(1);
        scl_m = 1'b1; wq(1);
        sda_m = 1'b1; wq(2);
    endtask

    task automatic send_bit(input bit b);
        sda_m = b;    wq(1);
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0; wq(1);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) send_bit(b[i]);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_m = 1'b1; wq(1);
        scl_m = 1'b1; wq(1);
        acked = !sda_line;
        wq(1);
        scl_m = 1'b0; wq(1);
        chk(sda_oe == 1'b0, "R12 release after ninth clock", sda_oe, 0);
    endtask

    function automatic bit addr_ok(input logic [7:0] a);
        return a[7:1] == {5'b00100, pins};
    endfunction

    function automatic logic [4:0] next_ptr(input logic [4:0] p);
        return (p >= 5'd21) ? 5'd0 : p + 5'd1;
    endfunction

    task automatic cmp_regs(input string tag);
        int bad = -1;
        for (int i = 0; i < NREG; i++)
            if (bad < 0 && regs[i*8 +: 8] !== exp_regs[i]) bad = i;
        if (bad < 0) chk(1'b1, tag, 0, 0);
        else chk(1'b0, $sformatf("%s reg%0d", tag, bad), regs[bad*8 +: 8], exp_regs[bad]);
    endtask

    // full transaction: address byte, then n further bytes (sub-address first)
    task automatic txn(input logic [7:0] a, input logic [7:0] bytes [8], input int n,
                       input string tag);
        bit ack;
        bit sel;
        logic [4:0] p;
        bus_start();
        send_byte(a, ack);
        sel = addr_ok(a);
        chk(ack == sel, {tag, " R2 address ack"}, ack, sel);
        p = 5'd0;
        for (int k = 0; k < n; k++) begin
            send_byte(bytes[k], ack);
            chk(ack == (sel && !a[0]), {tag, " R3/R9 byte ack"}, ack, sel && !a[0]);
            if (sel && !a[0]) begin
                if (k == 0) p = bytes[k][4:0];
                else begin
                    if (p < 5'd22) exp_regs[p] = bytes[k];
                    p = next_ptr(p);
                end
            end
        end
        bus_stop();
        cmp_regs({tag, " R5 contents"});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] b [8];
        bit ack;
        int unsigned seed;
        seed = $urandom(32'd20240517);
        for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R13 reset state
        chk(sda_oe == 1'b0, "R13 sda_oe after reset", sda_oe, 0);
        cmp_regs("R13 regs after reset");

        // R5 single write
        b[0] = 8'h03; b[1] = 8'hA5;
        txn(8'h24, b, 2, "R5 single");

        // R6/R7 burst across wrap
        b[0] = 8'h14; b[1] = 8'h11; b[2] = 8'h22; b[3] = 8'h33; b[4] = 8'h44;
        txn(8'h24, b, 5, "R7 wrap burst");
        chk(regs[0 +: 8] == 8'h33, "R7 reg0 overwritten", regs[0 +: 8], 8'h33);
        chk(regs[8 +: 8] == 8'h44, "R6 reg1 consecutive", regs[8 +: 8], 8'h44);

        // R3 wrong pin bits and wrong prefix
        b[0] = 8'h05; b[1] = 8'hEE; b[2] = 8'hEE;
        txn(8'h22, b, 3, "R3 pin mismatch");
        txn(8'h64, b, 3, "R3 prefix mismatch");

        // R4 upper sub-address bits ignored
        b[0] = 8'hE2; b[1] = 8'h5C;
        txn(8'h24, b, 2, "R4 upper bits");
        chk(regs[16 +: 8] == 8'h5C, "R4 reg2", regs[16 +: 8], 8'h5C);

        // R8 out-of-range pointer
        b[0] = 8'h1E; b[1] = 8'h77; b[2] = 8'h66;
        txn(8'h24, b, 3, "R8 out of range");
        chk(regs[0 +: 8] == 8'h66, "R8 wrap to reg0", regs[0 +: 8], 8'h66);

        // R9 read direction
        b[0] = 8'h04; b[1] = 8'h99;
        txn(8'h25, b, 2, "R9 read");

        // R1 address clocked without START after a STOP
        send_byte(8'h24, ack);
        chk(ack == 1'b0, "R1 no START no ack", ack, 0);
        bus_stop();

        // R10 repeated START inside a data byte
        bus_start();
        send_byte(8'h24, ack);
        send_byte(8'h07, ack);
        send_bits(8'hF0, 4);
        b[0] = 8'h08; b[1] = 8'h3C;
        txn(8'h24, b, 2, "R10 restart");
        chk(regs[56 +: 8] == 8'h00, "R10 partial not written", regs[56 +: 8], 0);

        // R11 STOP inside a data byte
        bus_start();
        send_byte(8'h24, ack);
        send_byte(8'h09, ack);
        send_bits(8'hFF, 5);
        bus_stop();
        cmp_regs("R11 stop mid byte");
        chk(regs[72 +: 8] == 8'h00, "R11 reg9 untouched", regs[72 +: 8], 0);

        // random mix
        for (int t = 0; t < 30; t++) begin
            logic [7:0] a;
            int n;
            a = ($urandom % 5 != 0) ? 8'h24 : 8'($urandom);
            n = 1 + int'($urandom % 6);
            for (int k = 0; k < 8; k++) b[k] = 8'($urandom);
            txn(a, b, n, "R6 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule